// File: doc/BRIEF.md
# Zero-Suppressing Digitizer Channel Processor

This block serves one channel of a free-running 10-bit flash ADC. Every ADC sample enters a delay line whose tap is set by a latency input. Because of this delay, a trigger that arrives late still finds the samples that came before it. When a trigger is accepted, the block opens an acquisition window of a programmable number of samples on the delayed stream. Inside the window it compares each sample with a threshold. For each sample above the threshold it writes two typed words: one holding the sample and one holding its time bin. The words are framed by two header words and one trailer word and go to a 32-bit FIFO write port.

The block runs at twice the sample rate. The ADC strobe `smp_valid` is high for one clock and then low for at least one clock. This leaves each sample two write slots, one for the ADC word and one for the time-bin word, so the port keeps up even when every sample in the window passes the threshold. Threshold, window length, channel and event identifiers are captured when the trigger is accepted. The latency tap is always taken live.

Every output word has bit 0 as even parity over bits 31:1, so the whole word has an even number of ones. Bits 31:29 hold a type tag: 001 first header, 010 second header, 011 ADC, 100 time bin, 101 trailer. The fields are placed as follows, and all other bits are zero:

| Word | Field bits |
|---|---|
| First header | module number in bits 6:1 |
| Second header | channel in bits 10:6, event in bits 3:1 |
| ADC | sample in bits 10:1 |
| Time | bin in bits 10:1 |
| Trailer | count of ADC words written in bits 11:1 |

Top module: `zs_chan_proc`

## Requirements
- R1: Strobes are numbered, and the trigger is taken on strobe n with latency L (0 to 100, larger values act as 100). Time bin k then carries the sample presented on strobe n+k-L, so bin L is the sample seen with the trigger.
- R2: The window covers the N strobes after the trigger strobe, as bins 0 to N-1. N is the `cfg_nsamp` value captured at the trigger. A value of 0 acts as 1 and values above 1024 act as 1024. A change of `cfg_nsamp` or `cfg_thresh` during a window has no effect on that event.
- R3: A bin produces output only when its sample is strictly greater than the captured threshold. Its ADC word (tag 011) is followed on the next clock by a time word (tag 100) carrying the bin number.
- R4: The first header (tag 011 is not used here; tag 001) appears on `fifo_wr` on the clock after the trigger strobe. The second header (tag 010) appears on the clock after that.
- R5: Each event ends with exactly one trailer word (tag 101) whose count equals the number of ADC words written for that event.
- R6: Every word follows the tag codes and field positions given above, with all unused bits zero.
- R7: Bit 0 of every written word makes the count of ones in the 32-bit word even.
- R8: A trigger that arrives while `busy` is high is ignored. It produces no header and does not change the event in progress.
- R9: `busy` is low after reset. It goes high on the clock the first header appears and stays high through the clock the trailer appears. It is low on the clock after the trailer.
- R10: If `fifo_full` is high on the strobe of an over-threshold bin, that bin's ADC and time words are both omitted and left out of the trailer count. `ovf` is then set and stays set until the next accepted trigger clears it. The trailer is written regardless.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock, twice the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | ADC strobe, one clock high then at least one low |
| smp_data | input | 10 | ADC sample, valid with `smp_valid` |
| trig | input | 1 | Trigger, taken on a strobe clock |
| cfg_lat | input | 7 | Latency tap in strobes |
| cfg_thresh | input | 10 | Threshold for zero suppression |
| cfg_nsamp | input | 11 | Window length in samples |
| id_module | input | 6 | Module number for the first header |
| id_chan | input | 5 | Channel number for the second header |
| id_event | input | 3 | Event number for the second header |
| fifo_full | input | 1 | FIFO full flag |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_wdata | output | 32 | FIFO write word |
| busy | output | 1 | Event in progress |
| ovf | output | 1 | A sample was lost to a full FIFO in this event |

## Verification
The bench sweeps latency from 0 up to the 100-strobe maximum against several window lengths and three thresholds. It computes every expected word from the strobe index of each sample. An off-by-one in the delay tap or in the first bin would shift every ADC value against its time word. A threshold compared with greater-or-equal would add words at samples equal to the limit. Separate runs cover these cases:
- Window lengths of 0 and 1 and the full 1024. A wrong length check would stretch or cut the record.
- Retriggering and reconfiguring during a window. A design that took these would emit a second header or change the length.
- A full FIFO on selected bins. A design that still wrote those bins, counted them, or skipped the trailer would leave the record or `ovf` wrong.

// File: rtl/zs_pkg.sv
package zs_pkg;

  localparam int WORD_W    = 32;
  localparam int PAY_W     = 28;
  localparam int H2_CH_LSB = 5;   // channel field sits at word bits 10:6

  typedef enum logic [2:0] {
    TAG_NONE = 3'b000,
    TAG_HDR1 = 3'b001,
    TAG_HDR2 = 3'b010,
    TAG_ADC  = 3'b011,
    TAG_TIME = 3'b100,
    TAG_TRL  = 3'b101
  } word_tag_e;

  // Tag on top, payload below, even parity in bit 0.
  function automatic logic [WORD_W-1:0] pack_word(word_tag_e tag, logic [PAY_W-1:0] pay);
    logic [WORD_W-2:0] body;
    body = {tag, pay};
    return {body, ^body};
  endfunction

  // Window length after clamping to the legal range.
  function automatic int unsigned win_len(int unsigned req, int unsigned maxv);
    if (req == 0)   return 1;
    if (req > maxv) return maxv;
    return req;
  endfunction

endpackage

// File: rtl/zs_delay_line.sv
module zs_delay_line #(
  parameter int W       = 10,
  parameter int MAX_LAT = 100,
  parameter int SEL_W   = $clog2(MAX_LAT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift,
  input  logic [W-1:0]     din,
  input  logic [SEL_W-1:0] sel,
  output logic [W-1:0]     dout
);
  localparam int DEPTH = MAX_LAT + 1;

  logic [W-1:0]     taps [DEPTH];
  logic [SEL_W-1:0] sel_eff;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stg
    logic [W-1:0] q;
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)     q <= '0;
        else if (shift) q <= din;
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)     q <= '0;
        else if (shift) q <= g_stg[i-1].q;
    end
    assign taps[i] = q;
  end

  assign sel_eff = (sel > SEL_W'(MAX_LAT)) ? SEL_W'(MAX_LAT) : sel;
  assign dout    = taps[sel_eff];

endmodule

// File: rtl/zs_seq.sv
module zs_seq
  import zs_pkg::*;
#(
  parameter int SMP_W   = 10,
  parameter int MAX_WIN = 1024,
  parameter int MOD_W   = 6,
  parameter int CH_W    = 5,
  parameter int EV_W    = 3,
  parameter int BIN_W   = $clog2(MAX_WIN),
  parameter int NCNT_W  = $clog2(MAX_WIN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic              trig,
  input  logic [SMP_W-1:0]  dly_smp,
  input  logic [SMP_W-1:0]  cfg_thresh,
  input  logic [NCNT_W-1:0] cfg_nsamp,
  input  logic [MOD_W-1:0]  id_module,
  input  logic [CH_W-1:0]   id_chan,
  input  logic [EV_W-1:0]   id_event,
  input  logic              fifo_full,
  output word_tag_e         emit_tag,
  output logic [PAY_W-1:0]  emit_pay,
  output logic              accept,
  output logic              drop,
  output logic              busy,
  output logic              ovf,
  output logic [SMP_W-1:0]  thr_q
);
  typedef enum logic [1:0] {SQ_IDLE, SQ_HDR2, SQ_WIN, SQ_TAIL} sq_state_e;

  sq_state_e         st;
  logic [BIN_W-1:0]  bin_q, pend_bin_q;
  logic [NCNT_W-1:0] cnt_q, n_q;
  logic [CH_W-1:0]   ch_q;
  logic [EV_W-1:0]   ev_q;
  logic              pend_q, tail_vis_q, ovf_q;
  logic              take, adc_go, win_last;

  assign busy     = (st != SQ_IDLE) || tail_vis_q;
  assign accept   = (st == SQ_IDLE) && !tail_vis_q && smp_valid && trig;
  assign take     = (st == SQ_WIN) && smp_valid && (dly_smp > thr_q);
  assign drop     = take && fifo_full;
  assign adc_go   = take && !fifo_full;
  assign win_last = (st == SQ_WIN) && smp_valid && (NCNT_W'(bin_q) == n_q - NCNT_W'(1));
  assign ovf      = ovf_q;

  always_comb begin
    emit_tag = TAG_NONE;
    emit_pay = '0;
    if (accept) begin
      emit_tag = TAG_HDR1;
      emit_pay = PAY_W'(id_module);
    end else if (st == SQ_HDR2) begin
      emit_tag = TAG_HDR2;
      emit_pay = (PAY_W'(ch_q) << H2_CH_LSB) | PAY_W'(ev_q);
    end else if (pend_q) begin
      emit_tag = TAG_TIME;
      emit_pay = PAY_W'(pend_bin_q);
    end else if (adc_go) begin
      emit_tag = TAG_ADC;
      emit_pay = PAY_W'(dly_smp);
    end else if (st == SQ_TAIL) begin
      emit_tag = TAG_TRL;
      emit_pay = PAY_W'(cnt_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= SQ_IDLE;
      bin_q      <= '0;
      pend_bin_q <= '0;
      cnt_q      <= '0;
      n_q        <= NCNT_W'(1);
      thr_q      <= '0;
      ch_q       <= '0;
      ev_q       <= '0;
      pend_q     <= 1'b0;
      tail_vis_q <= 1'b0;
      ovf_q      <= 1'b0;
    end else begin
      pend_q     <= (emit_tag == TAG_ADC);
      pend_bin_q <= bin_q;
      tail_vis_q <= (emit_tag == TAG_TRL);
      if (emit_tag == TAG_ADC) cnt_q <= cnt_q + NCNT_W'(1);
      if (drop)                ovf_q <= 1'b1;
      unique case (st)
        SQ_IDLE: if (accept) begin
          st    <= SQ_HDR2;
          bin_q <= '0;
          cnt_q <= '0;
          n_q   <= NCNT_W'(win_len(32'(cfg_nsamp), MAX_WIN));
          thr_q <= cfg_thresh;
          ch_q  <= id_chan;
          ev_q  <= id_event;
          ovf_q <= 1'b0;
        end
        SQ_HDR2: st <= SQ_WIN;
        SQ_WIN: if (smp_valid) begin
          bin_q <= bin_q + BIN_W'(1);
          if (win_last) st <= SQ_TAIL;
        end
        SQ_TAIL: if (!pend_q) st <= SQ_IDLE;
        default: st <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/zs_wr_port.sv
module zs_wr_port
  import zs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  word_tag_e         emit_tag,
  input  logic [PAY_W-1:0]  emit_pay,
  output logic              fifo_wr,
  output logic [WORD_W-1:0] fifo_wdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_wr    <= 1'b0;
      fifo_wdata <= '0;
    end else begin
      fifo_wr    <= (emit_tag != TAG_NONE);
      fifo_wdata <= (emit_tag != TAG_NONE) ? pack_word(emit_tag, emit_pay) : '0;
    end
  end
endmodule

// File: rtl/zs_chan_proc.sv
module zs_chan_proc
  import zs_pkg::*;
#(
  parameter int SMP_W   = 10,
  parameter int MAX_LAT = 100,
  parameter int MAX_WIN = 1024,
  parameter int MOD_W   = 6,
  parameter int CH_W    = 5,
  parameter int EV_W    = 3,
  localparam int LAT_W  = $clog2(MAX_LAT + 1),
  localparam int NCNT_W = $clog2(MAX_WIN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [SMP_W-1:0]  smp_data,
  input  logic              trig,
  input  logic [LAT_W-1:0]  cfg_lat,
  input  logic [SMP_W-1:0]  cfg_thresh,
  input  logic [NCNT_W-1:0] cfg_nsamp,
  input  logic [MOD_W-1:0]  id_module,
  input  logic [CH_W-1:0]   id_chan,
  input  logic [EV_W-1:0]   id_event,
  input  logic              fifo_full,
  output logic              fifo_wr,
  output logic [31:0]       fifo_wdata,
  output logic              busy,
  output logic              ovf
);
  // Named internal events, also watched by the bound checker.
  logic [SMP_W-1:0] dly_smp;
  logic [SMP_W-1:0] thr_q;
  word_tag_e        emit_tag;
  logic [PAY_W-1:0] emit_pay;
  logic             accept;
  logic             drop;

  zs_delay_line #(.W(SMP_W), .MAX_LAT(MAX_LAT), .SEL_W(LAT_W)) u_dly (
    .clk(clk), .rst_n(rst_n), .shift(smp_valid), .din(smp_data),
    .sel(cfg_lat), .dout(dly_smp)
  );

  zs_seq #(
    .SMP_W(SMP_W), .MAX_WIN(MAX_WIN), .MOD_W(MOD_W), .CH_W(CH_W), .EV_W(EV_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .trig(trig),
    .dly_smp(dly_smp), .cfg_thresh(cfg_thresh), .cfg_nsamp(cfg_nsamp),
    .id_module(id_module), .id_chan(id_chan), .id_event(id_event),
    .fifo_full(fifo_full), .emit_tag(emit_tag), .emit_pay(emit_pay),
    .accept(accept), .drop(drop), .busy(busy), .ovf(ovf), .thr_q(thr_q)
  );

  zs_wr_port u_wr (
    .clk(clk), .rst_n(rst_n), .emit_tag(emit_tag), .emit_pay(emit_pay),
    .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata)
  );

endmodule

// File: rtl/zs_chan_chk.sv
module zs_chan_chk #(
  parameter int SMP_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             accept,
  input logic             drop,
  input logic             busy,
  input logic             ovf,
  input logic             fifo_wr,
  input logic [31:0]      fifo_wdata,
  input logic [SMP_W-1:0] thr_q
);
  logic [2:0] tag;
  assign tag = fifo_wdata[31:29];

  p_hdr1_after_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (fifo_wr && tag == 3'b001));

  p_hdr2_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && tag == 3'b001) |=> (fifo_wr && tag == 3'b010));

  p_time_follows_adc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && tag == 3'b011) |=> (fifo_wr && tag == 3'b100));

  p_adc_above_thr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && tag == 3'b011) |-> (fifo_wdata[SMP_W:1] > thr_q));

  p_even_parity_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> (^fifo_wdata == 1'b0));

  p_single_hdr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> !(fifo_wr && tag == 3'b001));

  p_busy_on_hdr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  p_idle_after_trl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && tag == 3'b101) |=> !busy);

  p_ovf_on_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ovf);

endmodule

bind zs_chan_proc zs_chan_chk #(.SMP_W(SMP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .drop(drop), .busy(busy),
  .ovf(ovf), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .thr_q(thr_q)
);

// File: tb/zs_chan_proc_tb.sv
`timescale 1ns/1ps
module zs_chan_proc_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [9:0]  smp_data = '0;
  logic        trig = 1'b0;
  logic [6:0]  cfg_lat = '0;
  logic [9:0]  cfg_thresh = '0;
  logic [10:0] cfg_nsamp = 11'd1;
  logic [5:0]  id_module = '0;
  logic [4:0]  id_chan = '0;
  logic [2:0]  id_event = '0;
  logic        fifo_full = 1'b0;
  logic        fifo_wr;
  logic [31:0] fifo_wdata;
  logic        busy, ovf;

  int checks = 0;
  int errors = 0;
  int g = 0;               // strobe index
  logic [31:0] got_q[$];
  logic [31:0] exp_q[$];
  logic prev_trl = 1'b0;

  always #2.5 clk = ~clk;

  zs_chan_proc u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .trig(trig), .cfg_lat(cfg_lat), .cfg_thresh(cfg_thresh), .cfg_nsamp(cfg_nsamp),
    .id_module(id_module), .id_chan(id_chan), .id_event(id_event),
    .fifo_full(fifo_full), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
    .busy(busy), .ovf(ovf)
  );

  function automatic logic [9:0] samp(int idx);
    return 10'((idx * 37 + (idx / 7) * 113 + 5) % 1024);
  endfunction

  // Tag codes and field shifts restated from the requirements (R6, R7).
  function automatic logic [31:0] bword(int tag, int field);
    logic [31:0] w;
    w = (32'(tag) << 29) | (32'(field) << 1);
    if ($countones(w) % 2 == 1) w[0] = 1'b1;
    return w;
  endfunction

  function automatic string req_of(logic [31:0] w);
    case (w[31:29])
      3'b001, 3'b010: return "R4";
      3'b011:         return "R1";
      3'b100:         return "R3";
      default:        return "R5";
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // Output monitor, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_trl) check(busy == 1'b0, "R9", "busy after trailer", 32'(busy), 32'd0);
      if (fifo_wr) begin
        got_q.push_back(fifo_wdata);
        check($countones(fifo_wdata) % 2 == 0, "R7", "parity", fifo_wdata, 32'd0);
        check(busy == 1'b1, "R9", "busy with word", 32'(busy), 32'd1);
      end
      prev_trl = fifo_wr && (fifo_wdata[31:29] == 3'b101);
    end
  end

  task automatic strobe(bit t, bit f);
    @(posedge clk); #1;
    smp_valid = 1'b1; smp_data = samp(g); trig = t; fifo_full = f;
    @(posedge clk); #1;
    smp_valid = 1'b0; trig = 1'b0; fifo_full = 1'b0;
    g++;
  endtask

  // mode 0: plain, 1: full on bins k%3==0, 2: retrigger and reconfigure in window
  task automatic run_event(int lat, int nw, int thr, int mode);
    int n, eff, cnt;
    bit dropped;
    cfg_lat = 7'(lat); cfg_thresh = 10'(thr); cfg_nsamp = 11'(nw);
    id_module = 6'(g % 64); id_chan = 5'((g / 3) % 32); id_event = 3'((g % 5) + 1);
    eff = (nw == 0) ? 1 : (nw > 1024) ? 1024 : nw;
    n = g;
    exp_q.delete(); got_q.delete();
    exp_q.push_back(bword(1, int'(id_module)));
    exp_q.push_back(bword(2, (int'(id_chan) << 5) | int'(id_event)));
    cnt = 0; dropped = 0;
    for (int k = 0; k < eff; k++) begin
      logic [9:0] s;
      s = samp(n + k - lat);                       // R1 tap
      if (int'(s) > thr) begin                     // R3 strict compare
        if (mode == 1 && k % 3 == 0) dropped = 1;  // R10
        else begin
          exp_q.push_back(bword(3, int'(s)));
          exp_q.push_back(bword(4, k));
          cnt++;
        end
      end
    end
    exp_q.push_back(bword(5, cnt));                // R5
    strobe(1'b1, 1'b0);
    if (mode == 2) begin cfg_nsamp = 11'd1; cfg_thresh = 10'd0; end  // R2: ignored
    for (int k = 0; k < eff; k++)
      strobe(mode == 2 && k % 4 == 1, mode == 1 && k % 3 == 0);     // R8 retrigger
    for (int k = 0; k < 3; k++) strobe(1'b0, 1'b0);
    check(got_q.size() == exp_q.size(), "R2", "word count",
          32'(got_q.size()), 32'(exp_q.size()));
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      check(got_q[i] == exp_q[i], req_of(exp_q[i]), $sformatf("R6 word %0d", i),
            got_q[i], exp_q[i]);
    check(ovf == dropped, "R10", "ovf", 32'(ovf), 32'(dropped));
    check(busy == 1'b0, "R9", "idle after event", 32'(busy), 32'd0);
  endtask

  initial begin
    #(5.0 * 190000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int lats[5] = '{0, 1, 2, 7, 100};
    int lens[3] = '{1, 5, 23};
    int thrs[3] = '{0, 511, 1023};
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(fifo_wr == 1'b0, "R9", "reset wr", 32'(fifo_wr), 32'd0);
    check(busy == 1'b0, "R9", "reset busy", 32'(busy), 32'd0);
    check(ovf == 1'b0, "R10", "reset ovf", 32'(ovf), 32'd0);
    for (int i = 0; i < 110; i++) strobe(1'b0, 1'b0);   // fill delay history
    foreach (lats[a]) foreach (lens[b]) foreach (thrs[c])
      run_event(lats[a], lens[b], thrs[c], 0);
    run_event(3, 0, 100, 0);       // R2 zero length acts as one
    run_event(5, 2000, 950, 0);    // R2 clamp to 1024
    run_event(3, 30, 200, 1);      // R10 full FIFO
    run_event(4, 20, 300, 2);      // R8 retrigger, R2 latched config
    run_event(100, 1024, 900, 0);  // R1 deepest tap, longest window
    run_event(0, 6, 0, 0);         // R10 ovf cleared by new trigger
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule